// File: doc/BRIEF.md
# Parallel Overlapping Three-Tap Window Adder

The block sums three neighbouring samples for several positions at once. Each clock it can take one bus word that holds a run of narrow unsigned samples. It returns the sum for every window that fits wholly inside that word. With the default sizes, a 64-bit word carries eight 8-bit samples, and six lanes each produce a 10-bit sum.

Adjacent windows overlap, so the lanes share samples rather than fetching them again. Six windows need eight samples, not eighteen. For the results to form one unbroken output stream, the source must advance its read position by six samples per word, so consecutive words repeat the last two samples of the word before.

Inside, every lane is a two-level pipeline. The first level adds the lane's two lower samples and carries its third sample forward in a delay register. The second level adds that delayed sample to the registered partial sum. A valid flag travels beside the data, and a single output valid covers all lanes.

Top module: `overlap_window_adder`

## Requirements
- R1: While reset is high, and in the first cycle after it, `out_valid` is 0 and `out_sums` is all zeros.
- R2: Sample i of `in_word` is bits [8i+7:8i]. Sample 0 is in the least significant byte.
- R3: Lane k (k = 0..5) outputs sample k + sample k+1 + sample k+2 of one input word. Its sum is bits [10k+9:10k] of `out_sums`, so lane 0 is in the least significant field.
- R4: The sums are unsigned and 10 bits wide. They never wrap: a word of all 0xFF gives 765 in every lane.
- R5: A word accepted at clock edge e with `in_valid` high shows its sums, with `out_valid` high, in the cycle after edge e+2.
- R6: Words on consecutive cycles give results on consecutive cycles. The pipeline never stalls.
- R7: A cycle with `in_valid` low gives a cycle with `out_valid` low exactly three cycles later. The cycles on either side are unaffected.
- R8: A change to sample m alters only lanes max(0,m-2) through min(5,m). Samples 0 and 7 each feed one lane; samples 2 to 5 each feed three.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | `in_word` holds a word to process this cycle |
| in_word | input | 64 | Eight packed 8-bit samples |
| out_valid | output | 1 | `out_sums` holds a result this cycle |
| out_sums | output | 60 | Six packed 10-bit window sums, lane 0 lowest |

## Verification
Two things can happen in the same cycle. The first-level adder of every lane can take a new word while its second-level adder is finishing the word before. A shared sample can also reach three lanes at once. Both are provoked with back-to-back words, with valid gaps, with all-ones words, and with a single non-zero sample walked across the eight positions. A behavioural queue model, three entries deep, predicts every lane and the valid flag on every cycle. Each lane is judged separately, so a sum that leaks into a neighbour, or a delay register that is skipped, shows up as a wrong lane.

// File: rtl/owa_pkg.sv
package owa_pkg;

    localparam int DEF_SAMPLE_W = 8;
    localparam int DEF_BUS_W    = 64;
    localparam int WINDOW_TAPS  = 3;

    function automatic int lane_count(input int bus_w, input int sample_w);
        return bus_w / sample_w - (WINDOW_TAPS - 1);
    endfunction

    function automatic int sum_width(input int sample_w);
        return sample_w + 2;
    endfunction

    typedef struct packed {
        logic word_ok;
        logic half_ok;
        logic done_ok;
    } vpipe_t;

endpackage

// File: rtl/owa_unpack.sv
module owa_unpack #(
    parameter int SAMPLE_W = owa_pkg::DEF_SAMPLE_W,
    parameter int BUS_W    = owa_pkg::DEF_BUS_W,
    localparam int NSAMP   = BUS_W / SAMPLE_W
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             load,
    input  logic [BUS_W-1:0]                 word,
    output logic [NSAMP-1:0][SAMPLE_W-1:0]   samp
);
    logic [BUS_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst)       word_q <= '0;
        else if (load) word_q <= word;
    end

    for (genvar i = 0; i < NSAMP; i++) begin : g_slice
        assign samp[i] = word_q[i*SAMPLE_W +: SAMPLE_W];
    end

endmodule

// File: rtl/owa_lane.sv
module owa_lane #(
    parameter int SAMPLE_W = owa_pkg::DEF_SAMPLE_W,
    localparam int SUM_W   = owa_pkg::sum_width(SAMPLE_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en_lvl1,
    input  logic                en_lvl2,
    input  logic [SAMPLE_W-1:0] tap0,
    input  logic [SAMPLE_W-1:0] tap1,
    input  logic [SAMPLE_W-1:0] tap2,
    output logic [SUM_W-1:0]    sum
);
    logic [SAMPLE_W:0]   pair_q;
    logic [SAMPLE_W-1:0] tap2_dly_q;
    logic [SUM_W-1:0]    sum_q;

    // first level: pair sum, third operand held back one cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q     <= '0;
            tap2_dly_q <= '0;
        end else if (en_lvl1) begin
            pair_q     <= {1'b0, tap0} + {1'b0, tap1};
            tap2_dly_q <= tap2;
        end
    end

    // second level: partial sum meets the delayed operand
    always_ff @(posedge clk) begin
        if (rst)          sum_q <= '0;
        else if (en_lvl2) sum_q <= {1'b0, pair_q} + {2'b00, tap2_dly_q};
    end

    assign sum = sum_q;

endmodule

// File: rtl/overlap_window_adder.sv
module overlap_window_adder #(
    parameter int SAMPLE_W = owa_pkg::DEF_SAMPLE_W,
    parameter int BUS_W    = owa_pkg::DEF_BUS_W,
    localparam int NSAMP   = BUS_W / SAMPLE_W,
    localparam int LANES   = owa_pkg::lane_count(BUS_W, SAMPLE_W),
    localparam int SUM_W   = owa_pkg::sum_width(SAMPLE_W)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [BUS_W-1:0]       in_word,
    output logic                   out_valid,
    output logic [LANES*SUM_W-1:0] out_sums
);
    owa_pkg::vpipe_t vp_q;
    logic [NSAMP-1:0][SAMPLE_W-1:0] samp;
    logic [LANES-1:0][SUM_W-1:0]    lane_sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            vp_q <= '0;
        end else begin
            vp_q.word_ok <= in_valid;
            vp_q.half_ok <= vp_q.word_ok;
            vp_q.done_ok <= vp_q.half_ok;
        end
    end

    owa_unpack #(.SAMPLE_W(SAMPLE_W), .BUS_W(BUS_W)) unpack_i (
        .clk  (clk),
        .rst  (rst),
        .load (in_valid),
        .word (in_word),
        .samp (samp)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        owa_lane #(.SAMPLE_W(SAMPLE_W)) lane_i (
            .clk     (clk),
            .rst     (rst),
            .en_lvl1 (vp_q.word_ok),
            .en_lvl2 (vp_q.half_ok),
            .tap0    (samp[k]),
            .tap1    (samp[k+1]),
            .tap2    (samp[k+2]),
            .sum     (lane_sum[k])
        );
    end

    assign out_valid = vp_q.done_ok;
    assign out_sums  = lane_sum;

endmodule

// File: rtl/owa_checker.sv
module owa_checker #(
    parameter int SAMPLE_W = owa_pkg::DEF_SAMPLE_W,
    parameter int BUS_W    = owa_pkg::DEF_BUS_W,
    localparam int LANES   = owa_pkg::lane_count(BUS_W, SAMPLE_W),
    localparam int SUM_W   = owa_pkg::sum_width(SAMPLE_W)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic [BUS_W-1:0]       in_word,
    input logic                   out_valid,
    input logic [LANES*SUM_W-1:0] out_sums
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sums == '0));

    assert_valid_latency_R5: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    for (genvar k = 0; k < LANES; k++) begin : g_chk
        assert_sum_range_R4: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (out_sums[k*SUM_W +: SUM_W] <= SUM_W'(3 * ((1 << SAMPLE_W) - 1))));

        assert_lane_sum_R3: assert property (@(posedge clk) disable iff (rst)
            (since_rst == 2'd3 && out_valid) |->
            (out_sums[k*SUM_W +: SUM_W] ==
                SUM_W'($past(in_word[k*SAMPLE_W +: SAMPLE_W], 3)) +
                SUM_W'($past(in_word[(k+1)*SAMPLE_W +: SAMPLE_W], 3)) +
                SUM_W'($past(in_word[(k+2)*SAMPLE_W +: SAMPLE_W], 3))));
    end

endmodule

bind overlap_window_adder owa_checker #(.SAMPLE_W(SAMPLE_W), .BUS_W(BUS_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_sums  (out_sums)
);

// File: tb/overlap_window_adder_tb_top.sv
module overlap_window_adder_tb_top;

    localparam int NL = 6;
    localparam int SW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [63:0]   in_word = '0;
    logic          out_valid;
    logic [NL*SW-1:0] out_sums;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    string cur_tag = "R6";

    typedef struct {
        bit          v;
        int          s[NL];
        string       tag;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;

    overlap_window_adder dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .out_valid (out_valid),
        .out_sums  (out_sums)
    );

    function automatic int samp_of(input logic [63:0] w, input int i);
        return int'(w[i*8 +: 8]);
    endfunction

    // reference model: queue three entries deep, one push per clock
    always @(posedge clk) begin
        exp_t e;
        e.v = (!rst) && in_valid;
        e.tag = cur_tag;
        for (int k = 0; k < NL; k++)
            e.s[k] = samp_of(in_word, k) + samp_of(in_word, k+1) + samp_of(in_word, k+2);
        q.push_back(e);
        if (q.size() > 3) void'(q.pop_front());
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && q.size() == 3) begin
            chk(out_valid == q[0].v, q[0].v ? "R5" : "R7", int'(out_valid), int'(q[0].v));
            if (q[0].v) begin
                for (int k = 0; k < NL; k++)
                    chk(int'(out_sums[k*SW +: SW]) == q[0].s[k],
                        $sformatf("R3 lane%0d %s", k, q[0].tag),
                        int'(out_sums[k*SW +: SW]), q[0].s[k]);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            bad++;
            total++;
            $display("FAIL R6 watchdog actual=%0d expected=<%0d", cyc, 20000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic drive(input bit v, input logic [63:0] w);
        @(negedge clk);
        in_valid = v;
        in_word  = w;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: outputs cleared while in reset
        chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
        chk(out_sums == '0, "R1 sums", int'(out_sums[31:0]), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0 && out_sums == '0, "R1 after", int'(out_valid), 0);

        // R2: distinct value per byte position
        cur_tag = "R2";
        drive(1'b1, 64'h0807_0605_0403_0201);
        drive(1'b1, 64'h1070_0100_3000_0509);

        // R4: all ones, every lane 765
        cur_tag = "R4";
        drive(1'b1, {64{1'b1}});
        drive(1'b1, {8{8'hFE}});

        // R8: single non-zero sample walked across positions
        cur_tag = "R8";
        for (int m = 0; m < 8; m++) drive(1'b1, 64'(8'hC3) << (8*m));

        // R6: back-to-back overlapping stream
        cur_tag = "R6";
        for (int n = 0; n < 40; n++) begin
            logic [63:0] w;
            for (int b = 0; b < 8; b++) w[b*8 +: 8] = 8'((6*n + b) * 29 + 7);
            drive(1'b1, w);
        end

        // R7: valid gaps of several shapes
        cur_tag = "R7";
        for (int n = 0; n < 60; n++)
            drive((n % 3 != 1) && (n % 7 != 0), {$urandom, $urandom});

        drive(1'b0, '0);
        repeat (6) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule